// File: doc/BRIEF.md
# Open-Row SDRAM Command Sequencer

This block turns a stream of read and write requests, each carrying a row and a column address, into the command sequence for one bank of SDRAM. It keeps the most recently activated row open after each access. Every request then takes one of three paths. A request to the open row goes straight to a column command. A request with no row open first needs an activation. A request to a different row needs a precharge, then an activation, then the column command. Three small countdown timers enforce the minimum row-to-column gap, the precharge recovery time and the minimum row-open time. All timing values are parameters given in clock cycles.

Requests arrive on a valid/ready port. A request is accepted in the cycle in which its column command is decided. Until then `reqReady` stays low and the requester holds the request stable. The sequencer issues the activation or precharge that the request needs as soon as the timers allow it. Commands are registered, so each command reaches the memory pins one cycle after it is decided. Read data from the memory is passed back with a one-cycle valid strobe, exactly CAS-latency cycles after the READ appears on the pins.

Top module: `open_row_sequencer`

## Requirements
- R1: While reset is held and right after it, the command pins carry NOP, no row is open, `rdValid` is low, `reqReady` is low and `memAddr` is zero.
- R2: The command pins {cmdCsN,cmdRasN,cmdCasN,cmdWeN} carry NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 or PRECHARGE=0010, and at most one command is issued per cycle. `memAddr` carries the row with ACTIVE, the column with READ/WRITE, and zero otherwise.
- R3: READ or WRITE appears on the pins only while a row is open, and at least T_RCD cycles after the ACTIVE that opened that row. It always targets the row and column of the request that was accepted.
- R4: ACTIVE appears only while no row is open, and at least T_RP cycles after the last PRECHARGE.
- R5: PRECHARGE appears only while a row is open, only for a pending request to a different row, and at least T_RAS cycles after the ACTIVE.
- R6: The row stays open after an access. A request to the open row with T_RCD satisfied is accepted in the cycle it is presented, and requests to that row can be accepted on consecutive cycles.
- R7: `rdValid` pulses exactly CL cycles after each READ on the pins. `rdData` then equals `memRdata`, and it is zero when `rdValid` is low.
- R8: From the cycle a read is presented to its `rdValid`, the latency is CL+1 cycles for a hit and T_RCD+CL+1 cycles with no row open. With a different row open and T_RAS already met, it is T_RP+T_RCD+CL+1 cycles (defaults: 4, 7, 10).
- R9: The write data of an accepted write appears on `memWdata` in the same cycle as its WRITE command, and `memWdata` is zero in all other cycles.
- R10: `reqReady` is high only when the request's row is open and T_RCD is met. While `reqValid` is low, the pins carry NOP in the next cycle, whatever the address inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle (when valid) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqWdata | input | DATA_W | Write data |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| memAddr | output | max(ROW_W,COL_W) | Row or column address |
| memWdata | output | DATA_W | Write data sent with WRITE |
| memRdata | input | DATA_W | Read data from memory |
| rdValid | output | 1 | Read data valid strobe |
| rdData | output | DATA_W | Returned read data |

## Verification
Suppose the open-row register or the open flag held the wrong value. The next hit would then either trigger a needless PRECHARGE/ACTIVE pair or, worse, send a column command to the wrong row. Either fault shows on the pins one cycle after the decision, so the bench tracks the open row from the ACTIVE commands it sees and compares every column command against the request it accepted. A timer that is off by one shows up as a command gap one cycle too short, or as a path latency one cycle longer than the R8 values. A fault in the read-tag pipeline moves the `rdValid` pulse away from the cycle exactly CL cycles after the READ, so the first read exposes it.

// File: rtl/orseq_pkg.sv
package orseq_pkg;

  // Strobes decided by the control, one per command kind.
  typedef struct packed {
    logic act;
    logic pre;
    logic rd;
    logic wr;
  } seqStrobe_t;

  // Pin codes ordered {cs_n, ras_n, cas_n, we_n}.
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } memCmd_e;

endpackage

// File: rtl/orseq_timer.sv
module orseq_timer #(
  parameter int COUNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (COUNT > 1) ? $clog2(COUNT + 1) : 1;

  logic [CW-1:0] cnt;

  // Load COUNT-1 so that a command decided COUNT cycles after the load is legal.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(COUNT - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/orseq_ctrl.sv
module orseq_ctrl
  import orseq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rowMatch,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  logic rowOpen;
  logic rcdDone;
  logic rpDone;
  logic rasDone;
  logic colOk;

  orseq_timer #(.COUNT(T_RCD)) u_rcdTimer (
    .clk(clk), .rst_n(rst_n), .load(strobe.act), .expired(rcdDone)
  );

  orseq_timer #(.COUNT(T_RAS)) u_rasTimer (
    .clk(clk), .rst_n(rst_n), .load(strobe.act), .expired(rasDone)
  );

  orseq_timer #(.COUNT(T_RP)) u_rpTimer (
    .clk(clk), .rst_n(rst_n), .load(strobe.pre), .expired(rpDone)
  );

  assign colOk    = rowOpen && rowMatch && rcdDone;
  assign reqReady = colOk;

  // One decision per cycle: column on hit, close on conflict, open when empty.
  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (colOk) begin
        strobe.rd = !reqWrite;
        strobe.wr = reqWrite;
      end else if (rowOpen && !rowMatch && rasDone) begin
        strobe.pre = 1'b1;
      end else if (!rowOpen && rpDone) begin
        strobe.act = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowOpen <= 1'b0;
    end else if (strobe.act) begin
      rowOpen <= 1'b1;
    end else if (strobe.pre) begin
      rowOpen <= 1'b0;
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.act, strobe.pre, strobe.rd, strobe.wr}));

  assert_accept_is_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |-> (strobe.rd || strobe.wr));

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.act |=> rowOpen);

  assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pre |=> (!rowOpen && !reqReady));

endmodule

// File: rtl/orseq_datapath.sv
module orseq_datapath
  import orseq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13,
  parameter int CL     = 3,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rowMatch,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  memCmd_e           cmdQ;
  memCmd_e           cmdNext;
  logic [ADDR_W-1:0] addrNext;
  logic [ROW_W-1:0]  openRow;
  logic [CL-1:0]     tagPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      openRow <= '0;
    end else if (strobe.act) begin
      openRow <= reqRow;
    end
  end

  assign rowMatch = (openRow == reqRow);

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.act) begin
      cmdNext  = CMD_ACT;
      addrNext = ADDR_W'(reqRow);
    end else if (strobe.pre) begin
      cmdNext  = CMD_PRE;
    end else if (strobe.rd) begin
      cmdNext  = CMD_RD;
      addrNext = ADDR_W'(reqCol);
    end else if (strobe.wr) begin
      cmdNext  = CMD_WR;
      addrNext = ADDR_W'(reqCol);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ     <= CMD_NOP;
      memAddr  <= '0;
      memWdata <= '0;
    end else begin
      cmdQ     <= cmdNext;
      memAddr  <= addrNext;
      memWdata <= strobe.wr ? reqWdata : '0;
    end
  end

  assign {cmdCsN, cmdRasN, cmdCasN, cmdWeN} = cmdQ;

  // Read tag: entry 0 is set one cycle after the READ is on the pins.
  generate
    if (CL == 1) begin : g_tagOne
      always_ff @(posedge clk) begin
        if (!rst_n) tagPipe <= '0;
        else        tagPipe <= (cmdQ == CMD_RD);
      end
    end else begin : g_tagShift
      always_ff @(posedge clk) begin
        if (!rst_n) tagPipe <= '0;
        else        tagPipe <= {tagPipe[CL-2:0], (cmdQ == CMD_RD)};
      end
    end
  endgenerate

  assign rdValid = tagPipe[CL-1];
  assign rdData  = rdValid ? memRdata : '0;

  // Independent gap counters, measured on the pins, for the timing checks.
  localparam int LIM = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                      : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int SW  = $clog2(LIM + 2);

  logic [SW-1:0] sinceAct;
  logic [SW-1:0] sincePre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceAct <= SW'(LIM);
      sincePre <= SW'(LIM);
    end else begin
      sinceAct <= (cmdQ == CMD_ACT) ? SW'(1) :
                  (sinceAct < SW'(LIM)) ? sinceAct + 1'b1 : sinceAct;
      sincePre <= (cmdQ == CMD_PRE) ? SW'(1) :
                  (sincePre < SW'(LIM)) ? sincePre + 1'b1 : sincePre;
    end
  end

  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> (sinceAct >= SW'(T_RCD)));

  assert_rp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_ACT) |-> (sincePre >= SW'(T_RP)));

  assert_ras_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_PRE) |-> (sinceAct >= SW'(T_RAS)));

  assert_wdata_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (memWdata != '0) |-> (cmdQ == CMD_WR));

endmodule

// File: rtl/open_row_sequencer.sv
module open_row_sequencer
  import orseq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int CL     = 3,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 10,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  seqStrobe_t strobe;
  logic       rowMatch;

  orseq_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .rowMatch (rowMatch),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  orseq_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .rowMatch (rowMatch),
    .cmdCsN   (cmdCsN),
    .cmdRasN  (cmdRasN),
    .cmdCasN  (cmdCasN),
    .cmdWeN   (cmdWeN),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: tb/open_row_sequencer_tb.sv
module open_row_sequencer_tb;

  localparam int ROW_W = 13, COL_W = 10, DATA_W = 16;
  localparam int CL = 3, T_RCD = 3, T_RP = 3, T_RAS = 10;
  localparam int WATCHDOG = 100000;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [DATA_W-1:0] reqWdata = '0, memRdata = '0;
  logic reqReady, cmdCsN, cmdRasN, cmdCasN, cmdWeN, rdValid;
  logic [12:0] memAddr;
  logic [DATA_W-1:0] memWdata, rdData;

  always #5 clk = ~clk;

  open_row_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CL(CL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .rdValid(rdValid), .rdData(rdData));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Bench memory model and expectation state
  logic [DATA_W-1:0] bmem [0:3][0:15];
  logic [DATA_W-1:0] rdLine [0:CL-1];
  int dueQ[$];
  logic [DATA_W-1:0] datQ[$];
  bit benchOpen = 0;
  int benchRow = 0, lastAct = -1000, lastPre = -1000;
  bit pendAcc = 0, pendWr = 0, expNop = 0;
  int pendRow = 0, pendCol = 0;
  logic [DATA_W-1:0] pendData = '0;

  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        bmem[r][c] = DATA_W'(r * 4096 + c * 17 + 3);
    for (int i = 0; i < CL; i++) rdLine[i] = '0;
  end

  function automatic bit isCol(logic [3:0] p);
    return (p == P_RD) || (p == P_WR);
  endfunction

  always @(negedge clk) begin
    logic [3:0] pins;
    pins = {cmdCsN, cmdRasN, cmdCasN, cmdWeN};
    if (rst_n && !done) begin
      // column command follows acceptance by one cycle (R3, R9)
      if (pendAcc) begin
        check(pins == (pendWr ? P_WR : P_RD), "R3 column cmd", pins, pendWr ? P_WR : P_RD);
        check(memAddr == 13'(pendCol), "R2 column addr", memAddr, pendCol);
        check(benchOpen && benchRow == pendRow, "R3 row of column cmd", benchRow, pendRow);
        if (pendWr) check(memWdata == pendData, "R9 write data", memWdata, pendData);
      end else begin
        check(!isCol(pins), "R3 unrequested column cmd", pins, P_NOP);
      end
      if (pins != P_WR) check(memWdata == '0, "R9 wdata idle", memWdata, 0);
      if (expNop) check(pins == P_NOP, "R10 idle NOP", pins, P_NOP);
      // protocol timing
      if (pins == P_ACT) begin
        check(!benchOpen, "R4 act while open", benchOpen, 0);
        check(cyc - lastPre >= T_RP, "R4 tRP gap", cyc - lastPre, T_RP);
        benchOpen = 1; benchRow = int'(memAddr); lastAct = cyc;
      end else if (isCol(pins)) begin
        check(cyc - lastAct >= T_RCD, "R3 tRCD gap", cyc - lastAct, T_RCD);
        if (pins == P_RD) begin
          dueQ.push_back(cyc + CL);
          datQ.push_back(bmem[benchRow % 4][memAddr[3:0]]);
        end else begin
          bmem[benchRow % 4][memAddr[3:0]] = memWdata;
        end
      end else if (pins == P_PRE) begin
        check(benchOpen, "R5 pre while closed", benchOpen, 1);
        check(cyc - lastAct >= T_RAS, "R5 tRAS gap", cyc - lastAct, T_RAS);
        check(reqValid && int'(reqRow) != benchRow, "R5 pre needs conflict", reqRow, benchRow);
        benchOpen = 0; lastPre = cyc;
      end else begin
        check(pins == P_NOP, "R2 legal encoding", pins, P_NOP);
      end
      // read return (R7)
      if (rdValid) begin
        if (dueQ.size() == 0) check(0, "R7 spurious rdValid", 1, 0);
        else begin
          check(dueQ[0] == cyc, "R7 rdValid cycle", cyc, dueQ[0]);
          check(rdData == datQ[0], "R7 read data", rdData, datQ[0]);
          void'(dueQ.pop_front()); void'(datQ.pop_front());
        end
      end else begin
        check(rdData == '0, "R7 rdData quiet", rdData, 0);
        if (dueQ.size() != 0 && dueQ[0] == cyc) check(0, "R7 missing rdValid", 0, 1);
      end
      // ready only on open-row hit (R10)
      if (reqValid && reqReady)
        check(benchOpen && int'(reqRow) == benchRow, "R10 ready on hit only", reqRow, benchRow);
      pendAcc = reqValid && reqReady;
      pendWr = reqWrite; pendRow = int'(reqRow); pendCol = int'(reqCol); pendData = reqWdata;
      expNop = !reqValid;
      // memory read pipeline drive
      for (int i = CL - 1; i > 0; i--) rdLine[i] = rdLine[i-1];
      rdLine[0] = (pins == P_RD) ? bmem[benchRow % 4][memAddr[3:0]] : 16'hBAD0;
      memRdata = rdLine[CL-1];
    end
  end

  task automatic idle(int n);
    reqValid = 0;
    reqRow = ROW_W'($urandom % 8);
    reqCol = COL_W'($urandom % 16);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sendReq(bit wr, int row, int col, logic [DATA_W-1:0] d, output int accCyc);
    bit acc;
    reqValid = 1; reqWrite = wr; reqRow = ROW_W'(row); reqCol = COL_W'(col); reqWdata = d;
    acc = 0;
    while (!acc) begin
      @(negedge clk); acc = reqReady; accCyc = cyc;
      @(posedge clk); #1;
    end
  endtask

  task automatic timedRead(int row, int col, int expLat, string req);
    int p, a;
    idle(10);
    p = cyc;
    sendReq(0, row, col, '0, a);
    reqValid = 0;
    do @(negedge clk); while (!rdValid);
    check(cyc - p == expLat, req, cyc - p, expLat);
    @(posedge clk); #1;
  endtask

  initial begin
    int a;
    int acc4 [4];
    int row;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({cmdCsN, cmdRasN, cmdCasN, cmdWeN} == P_NOP, "R1 reset NOP", {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, P_NOP);
    check(!rdValid, "R1 reset rdValid", rdValid, 0);
    check(!reqReady, "R1 reset ready", reqReady, 0);
    check(memAddr == '0, "R1 reset addr", memAddr, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check(!reqReady, "R1 no row open after reset", reqReady, 0);
    @(posedge clk); #1;
    idle(4);                              // R10: address changes ignored while idle
    timedRead(1, 5, T_RCD + CL + 1, "R8 empty-path latency");
    timedRead(1, 6, CL + 1, "R8 hit-path latency R6");
    timedRead(2, 0, T_RP + T_RCD + CL + 1, "R8 conflict-path latency");
    // write then read back on the open row (R9)
    sendReq(1, 2, 1, 16'hA5A5, a);
    sendReq(0, 2, 1, '0, a);
    idle(8);
    // back-to-back hits (R6)
    for (int i = 0; i < 4; i++) sendReq(0, 2, 2 + i, '0, acc4[i]);
    for (int i = 1; i < 4; i++)
      check(acc4[i] - acc4[0] == i, "R6 back-to-back accept", acc4[i] - acc4[0], i);
    // immediate conflict before tRAS expires (R5)
    sendReq(0, 3, 9, '0, a);
    sendReq(0, 0, 4, '0, a);
    idle(6);
    // random traffic
    row = 0;
    for (int i = 0; i < 400; i++) begin
      int gap;
      if ($urandom % 2 == 0) row = $urandom % 4;
      sendReq(($urandom % 3) == 0, row, $urandom % 16, DATA_W'($urandom), a);
      gap = $urandom % 4;
      if (gap != 0) idle(gap - 1);
    end
    idle(20);
    check(dueQ.size() == 0, "R7 all reads returned", dueQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule